// File: doc/BRIEF.md
# Section Trace Message Unit

This block owns the section trace byte of a framed line signal, one byte per frame in each direction. On the transmit side it holds an outgoing message in a small store. On every frame-start pulse it presents the next byte of that message, wrapping at the message length. On the receive side it takes one trace byte per received frame. It finds the message boundaries with a rule that depends on the format, and collects complete messages. A message is accepted only after it has arrived identically several times in a row. The accepted message is then compared with an expected message held in a second store.

Three formats are selected by `fmt_sel`: a single repeated byte, a 16-byte message marked by the top bit of its first byte, and a 64-byte message terminated by carriage return and line feed. A byte-wide register port loads the transmit and expected stores and reads them back, along with the accepted message. The block raises a mismatch alarm when the accepted message differs from the expected one. It raises a trace-unstable flag when nothing settles for too long.

Top module: `trace_msg_unit`

## Requirements
- R1: `fmt_sel` sets the message length: 2'b00 gives 1 byte, 2'b01 gives 16 bytes, 2'b10 gives 64 bytes, and 2'b11 behaves as 2'b00. The length applies to both directions.
- R2: `reg_sel` picks a store: 2'b00 is the transmit store, 2'b01 the expected store, 2'b10 the accepted store (read only), and 2'b11 reads as zero. `reg_idx` is the byte index and `reg_rdata` follows the address combinationally. A write with `reg_wr` high updates the selected byte at the next clock edge. Writes to 2'b10 or 2'b11 change nothing. All stores are zero after reset.
- R3: At the clock edge where `frame_start` is high, `tx_j0` takes the transmit-store byte at the current index. The index then advances and wraps to 0 after the last byte of the message. In single-byte mode every frame carries byte 0. Without `frame_start`, `tx_j0` holds its value.
- R4: If a write to the transmit store hits the slot being sent in the same cycle as `frame_start`, the frame carries the old byte. The new byte goes out when that slot next comes up.
- R5: In 16-byte mode, a received byte with bit 7 set starts a message. The next 15 bytes with bit 7 clear complete it. Bytes with bit 7 clear are discarded while no message has been started.
- R6: In 64-byte mode, a carriage return (0x0D) followed by a line feed (0x0A) marks a message end. The first such pair after reset only aligns the receiver. A message counts as complete when 64 bytes since the last alignment end in that pair.
- R7: In single-byte mode, every received byte is a complete message.
- R8: A message is accepted when the same complete message arrives 3 times in a row; any different message restarts the count. The accepted store holds the message from the second clock edge after its final byte.
- R9: At acceptance, `mismatch_alarm` is set if the accepted message differs from the expected store over the message length, and cleared if it matches. Changes to the expected store have no effect until the next acceptance.
- R10: `trace_unstable` is set once 8 message lengths of received bytes pass with no persistent message held. It is cleared by the next acceptance.
- R11: After reset, `tx_j0`, `mismatch_alarm` and `trace_unstable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Message format for both directions |
| frame_start | input | 1 | Transmit frame pulse, one per frame |
| tx_j0 | output | 8 | Outgoing trace byte |
| rx_valid | input | 1 | Received trace byte strobe, one per frame |
| rx_j0 | input | 8 | Received trace byte |
| reg_wr | input | 1 | Store write strobe |
| reg_sel | input | 2 | Store select |
| reg_idx | input | 6 | Byte index within the store |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed byte |
| mismatch_alarm | output | 1 | Accepted message differs from expected |
| trace_unstable | output | 1 | No persistent message within the window |

## Verification
A register write into the transmit store and a frame-start pulse can land in the same clock cycle and address the same slot. The bench provokes this by raising both strobes in a single cycle, with the write index set to the slot the transmit index currently points to. It judges the result in two steps. The byte sent in that frame must be the old one. When the index comes around to the same slot again, the new byte must be sent. The receive side is exercised with random messages in all three formats, including persistency runs that are interrupted and alarm changes that are held back.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int TRACE_MAX  = 64;
  localparam int TRACE_IW   = $clog2(TRACE_MAX);
  localparam int TRACE_LW   = TRACE_IW + 1;
  localparam int SHORT_LEN  = 16;
  localparam logic [7:0] CHR_CR = 8'h0D;
  localparam logic [7:0] CHR_LF = 8'h0A;

  typedef logic [TRACE_MAX-1:0][7:0] trace_buf_t;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'b00,
    FMT_SHORT  = 2'b01,
    FMT_LONG   = 2'b10,
    FMT_ALT    = 2'b11
  } trace_fmt_e;

  function automatic logic [TRACE_LW-1:0] fmt_len(input logic [1:0] f);
    case (trace_fmt_e'(f))
      FMT_SHORT: fmt_len = TRACE_LW'(SHORT_LEN);
      FMT_LONG:  fmt_len = TRACE_LW'(TRACE_MAX);
      default:   fmt_len = TRACE_LW'(1);
    endcase
  endfunction
endpackage

// File: rtl/trace_tx_gen.sv
module trace_tx_gen
  import trace_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                frame_start,
  input  logic                wr_en,
  input  logic [TRACE_IW-1:0] wr_idx,
  input  logic [7:0]          wr_data,
  output trace_buf_t          ram_q,
  output logic [7:0]          tx_byte
);
  trace_buf_t          ram_d;
  logic [TRACE_IW-1:0] idx_q, idx_d;
  logic [TRACE_LW-1:0] len, idx_inc;
  logic [7:0]          tx_d;

  assign len     = fmt_len(fmt_sel);
  assign idx_inc = {1'b0, idx_q} + TRACE_LW'(1);

  always_comb begin
    ram_d = ram_q;
    ram_d[wr_idx] = wr_data;
  end

  always_comb begin
    idx_d = idx_q;
    tx_d  = tx_byte;
    if (frame_start) begin
      tx_d  = ram_q[idx_q];
      idx_d = (idx_inc >= len) ? '0 : idx_inc[TRACE_IW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_q   <= '0;
      idx_q   <= '0;
      tx_byte <= '0;
    end else begin
      if (wr_en) ram_q <= ram_d;
      if (frame_start) begin
        idx_q   <= idx_d;
        tx_byte <= tx_d;
      end
    end
  end
endmodule

// File: rtl/trace_rx_align.sv
module trace_rx_align
  import trace_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fmt_sel,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output trace_buf_t cap_q,
  output logic       done_q
);
  localparam logic [TRACE_IW-1:0] SHORT_LAST = TRACE_IW'(SHORT_LEN - 1);
  localparam logic [TRACE_IW-1:0] LONG_LAST  = TRACE_IW'(TRACE_MAX - 1);

  trace_buf_t          cap_d;
  logic [TRACE_IW-1:0] wp_q, wp_d;
  logic                sync_q, sync_d, done_d;
  logic [7:0]          prev_q;

  always_comb begin
    cap_d  = cap_q;
    wp_d   = wp_q;
    sync_d = sync_q;
    done_d = 1'b0;
    if (rx_valid) begin
      case (trace_fmt_e'(fmt_sel))
        FMT_SHORT: begin
          if (rx_byte[7]) begin
            cap_d[0] = rx_byte;
            wp_d     = TRACE_IW'(1);
            sync_d   = 1'b1;
          end else if (sync_q) begin
            cap_d[wp_q] = rx_byte;
            if (wp_q == SHORT_LAST) begin
              done_d = 1'b1;
              sync_d = 1'b0;
              wp_d   = '0;
            end else begin
              wp_d = wp_q + TRACE_IW'(1);
            end
          end
        end
        FMT_LONG: begin
          if (prev_q == CHR_CR && rx_byte == CHR_LF) begin
            if (sync_q && wp_q == LONG_LAST) begin
              cap_d[wp_q] = rx_byte;
              done_d      = 1'b1;
            end
            sync_d = 1'b1;
            wp_d   = '0;
          end else if (sync_q) begin
            cap_d[wp_q] = rx_byte;
            if (wp_q == LONG_LAST) begin
              sync_d = 1'b0;
              wp_d   = '0;
            end else begin
              wp_d = wp_q + TRACE_IW'(1);
            end
          end
        end
        default: begin
          cap_d[0] = rx_byte;
          done_d   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      wp_q   <= '0;
      sync_q <= 1'b0;
      prev_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (rx_valid) begin
        cap_q  <= cap_d;
        wp_q   <= wp_d;
        sync_q <= sync_d;
        prev_q <= rx_byte;
      end
    end
  end
endmodule

// File: rtl/trace_rx_persist.sv
module trace_rx_persist
  import trace_pkg::*;
#(
  parameter int PERSIST_N        = 3,
  parameter int UNSTABLE_PERIODS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                rx_valid,
  input  logic                done,
  input  trace_buf_t          cap,
  input  logic                exp_wr,
  input  logic [TRACE_IW-1:0] exp_idx,
  input  logic [7:0]          exp_data,
  output trace_buf_t          exp_q,
  output trace_buf_t          acc_q,
  output logic                mismatch,
  output logic                unstable
);
  localparam int CW = $clog2(PERSIST_N + 1);
  localparam int FW = $clog2(UNSTABLE_PERIODS * TRACE_MAX + 1);

  trace_buf_t          cand_q, exp_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [FW-1:0]       fcnt_q, fcnt_d, lim;
  logic [TRACE_LW-1:0] len;
  logic [TRACE_MAX-1:0] same_v, exp_v;
  logic same_cand, match_exp, accept, load_cand, held, unst_d, mism_d;

  assign len = fmt_len(fmt_sel);
  assign lim = FW'(UNSTABLE_PERIODS) * FW'(len);

  for (genvar i = 0; i < TRACE_MAX; i++) begin : g_cmp
    assign same_v[i] = (TRACE_LW'(i) >= len) || (cap[i] == cand_q[i]);
    assign exp_v[i]  = (TRACE_LW'(i) >= len) || (cap[i] == exp_q[i]);
  end
  assign same_cand = &same_v;
  assign match_exp = &exp_v;

  always_comb begin
    exp_d = exp_q;
    exp_d[exp_idx] = exp_data;
  end

  always_comb begin
    accept    = 1'b0;
    load_cand = 1'b0;
    cnt_d     = cnt_q;
    if (done) begin
      if (same_cand) begin
        if (cnt_q == CW'(PERSIST_N - 1)) begin
          accept = 1'b1;
          cnt_d  = CW'(PERSIST_N);
        end else if (cnt_q < CW'(PERSIST_N)) begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        load_cand = 1'b1;
        cnt_d     = CW'(1);
      end
    end
    held   = (cnt_q == CW'(PERSIST_N));
    fcnt_d = fcnt_q;
    if (accept || held)                fcnt_d = '0;
    else if (rx_valid && fcnt_q < lim) fcnt_d = fcnt_q + FW'(1);
    unst_d = accept ? 1'b0 : ((fcnt_d >= lim) ? 1'b1 : unstable);
    mism_d = accept ? !match_exp : mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q    <= '0;
      acc_q    <= '0;
      cand_q   <= '0;
      cnt_q    <= '0;
      fcnt_q   <= '0;
      mismatch <= 1'b0;
      unstable <= 1'b0;
    end else begin
      if (exp_wr)    exp_q  <= exp_d;
      if (accept)    acc_q  <= cap;
      if (load_cand) cand_q <= cap;
      cnt_q    <= cnt_d;
      fcnt_q   <= fcnt_d;
      mismatch <= mism_d;
      unstable <= unst_d;
    end
  end
endmodule

// File: rtl/trace_msg_unit.sv
module trace_msg_unit
  import trace_pkg::*;
#(
  parameter int PERSIST_N        = 3,
  parameter int UNSTABLE_PERIODS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                frame_start,
  output logic [7:0]          tx_j0,
  input  logic                rx_valid,
  input  logic [7:0]          rx_j0,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [TRACE_IW-1:0] reg_idx,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic                mismatch_alarm,
  output logic                trace_unstable
);
  trace_buf_t tx_ram, exp_ram, acc_ram, cap_w;
  logic       done_w;

  trace_tx_gen u_tx (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .frame_start(frame_start),
    .wr_en(reg_wr && reg_sel == 2'b00), .wr_idx(reg_idx), .wr_data(reg_wdata),
    .ram_q(tx_ram), .tx_byte(tx_j0)
  );

  trace_rx_align u_align (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .rx_valid(rx_valid),
    .rx_byte(rx_j0), .cap_q(cap_w), .done_q(done_w)
  );

  trace_rx_persist #(.PERSIST_N(PERSIST_N), .UNSTABLE_PERIODS(UNSTABLE_PERIODS)) u_persist (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .rx_valid(rx_valid),
    .done(done_w), .cap(cap_w),
    .exp_wr(reg_wr && reg_sel == 2'b01), .exp_idx(reg_idx), .exp_data(reg_wdata),
    .exp_q(exp_ram), .acc_q(acc_ram),
    .mismatch(mismatch_alarm), .unstable(trace_unstable)
  );

  always_comb begin
    case (reg_sel)
      2'b00:   reg_rdata = tx_ram[reg_idx];
      2'b01:   reg_rdata = exp_ram[reg_idx];
      2'b10:   reg_rdata = acc_ram[reg_idx];
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/trace_msg_unit_chk.sv
module trace_msg_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] fmt_sel,
  input logic       frame_start,
  input logic [7:0] tx_j0,
  input logic       rx_valid,
  input logic       done_w,
  input logic       mismatch_alarm,
  input logic       trace_unstable
);
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(tx_j0));

  // R9
  alarm_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> $stable(mismatch_alarm));

  // R10
  unstable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_unstable) |-> $past(rx_valid));

  // R10
  unstable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trace_unstable) |-> $past(done_w));

  // R7
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel == 2'b00 && rx_valid) |=> done_w);

  // R5
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |-> $past(rx_valid));
endmodule

bind trace_msg_unit trace_msg_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .frame_start(frame_start),
  .tx_j0(tx_j0), .rx_valid(rx_valid), .done_w(done_w),
  .mismatch_alarm(mismatch_alarm), .trace_unstable(trace_unstable)
);

// File: tb/trace_msg_unit_bench.sv
module trace_msg_unit_bench;
  logic       clk, rst_n, frame_start, rx_valid, reg_wr;
  logic [1:0] fmt_sel, reg_sel;
  logic [7:0] tx_j0, rx_j0, reg_wdata, reg_rdata;
  logic [5:0] reg_idx;
  logic       mismatch_alarm, trace_unstable;
  int n_chk = 0, n_err = 0;

  trace_msg_unit u_trace_msg_unit (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .frame_start(frame_start),
    .tx_j0(tx_j0), .rx_valid(rx_valid), .rx_j0(rx_j0), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mismatch_alarm(mismatch_alarm),
    .trace_unstable(trace_unstable)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic [1:0] f);
    @(negedge clk);
    rst_n = 1'b0; fmt_sel = f;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(input logic [1:0] s, input int i, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_idx = 6'(i); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, input int i, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_idx = 6'(i);
    #1 d = reg_rdata;
  endtask

  task automatic tx_frame(output logic [7:0] d);
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    #1 d = tx_j0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_j0 = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_msg(input logic [63:0][7:0] m, input int len);
    for (int i = 0; i < len; i++) send_byte(m[i]);
  endtask

  task automatic load_msg(input logic [1:0] s, input logic [63:0][7:0] m, input int len);
    for (int i = 0; i < len; i++) reg_write(s, i, m[i]);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [63:0][7:0] mk_short();
    logic [63:0][7:0] m = '0;
    m[0] = 8'h80 | 8'($urandom);
    for (int i = 1; i < 16; i++) m[i] = 8'($urandom) & 8'h7F;
    return m;
  endfunction

  function automatic logic [63:0][7:0] mk_long();
    logic [63:0][7:0] m;
    for (int i = 0; i < 62; i++) m[i] = 8'h20 + 8'($urandom % 95);
    m[62] = 8'h0D; m[63] = 8'h0A;
    return m;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [63:0][7:0] ma, mb, mc, mt;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; fmt_sel = 2'b00; frame_start = 1'b0; rx_valid = 1'b0;
    rx_j0 = '0; reg_wr = 1'b0; reg_sel = '0; reg_idx = '0; reg_wdata = '0;

    // R11 reset state
    do_reset(2'b00);
    #1;
    chk("R11 tx_j0", 32'(tx_j0), 0);
    chk("R11 mismatch", 32'(mismatch_alarm), 0);
    chk("R11 unstable", 32'(trace_unstable), 0);
    reg_read(2'b00, 5, v); chk("R2 reset store", 32'(v), 0);

    // R2 register port
    reg_write(2'b00, 3, 8'hA5);
    reg_write(2'b01, 7, 8'h3C);
    reg_write(2'b10, 0, 8'hFF);
    reg_write(2'b11, 0, 8'hEE);
    reg_read(2'b00, 3, v); chk("R2 tx store", 32'(v), 32'hA5);
    reg_read(2'b01, 7, v); chk("R2 exp store", 32'(v), 32'h3C);
    reg_read(2'b10, 0, v); chk("R2 accepted read only", 32'(v), 0);
    reg_read(2'b11, 0, v); chk("R2 sel3 zero", 32'(v), 0);

    // R3 single-byte transmit
    do_reset(2'b00);
    reg_write(2'b00, 0, 8'h5A);
    reg_write(2'b00, 1, 8'h11);
    for (int k = 0; k < 4; k++) begin tx_frame(v); chk("R3 single", 32'(v), 32'h5A); end

    // R1 R3 16-byte transmit, random content
    do_reset(2'b01);
    mt = mk_short();
    load_msg(2'b00, mt, 16);
    for (int k = 0; k < 20; k++) begin tx_frame(v); chk("R3 short seq", 32'(v), 32'(mt[k % 16])); end
    // R4 collision: index now 4
    @(negedge clk);
    frame_start = 1'b1; reg_wr = 1'b1; reg_sel = 2'b00; reg_idx = 6'd4; reg_wdata = ~mt[4];
    @(negedge clk);
    frame_start = 1'b0; reg_wr = 1'b0;
    #1 chk("R4 old byte sent", 32'(tx_j0), 32'(mt[4]));
    mt[4] = ~mt[4];
    for (int k = 21; k < 37; k++) begin tx_frame(v); chk("R4 later frames", 32'(v), 32'(mt[k % 16])); end

    // R1 R3 64-byte transmit
    do_reset(2'b10);
    mt = mk_long();
    load_msg(2'b00, mt, 64);
    for (int k = 0; k < 70; k++) begin tx_frame(v); chk("R3 long seq", 32'(v), 32'(mt[k % 64])); end

    // R5 R8 R9 16-byte receive
    do_reset(2'b01);
    ma = mk_short(); mb = mk_short();
    load_msg(2'b01, ma, 16);
    send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
    send_msg(ma, 16); send_msg(ma, 16); settle();
    reg_read(2'b10, 0, v); chk("R8 not yet accepted", 32'(v), 0);
    send_msg(ma, 16); settle();
    for (int i = 0; i < 16; i++) begin reg_read(2'b10, i, v); chk("R5 R8 accepted", 32'(v), 32'(ma[i])); end
    chk("R9 match", 32'(mismatch_alarm), 0);
    send_msg(mb, 16); send_msg(mb, 16); send_msg(mb, 16); settle();
    chk("R9 mismatch set", 32'(mismatch_alarm), 1);
    reg_read(2'b10, 1, v); chk("R8 second accept", 32'(v), 32'(mb[1]));
    load_msg(2'b01, mb, 16);
    send_msg(mb, 16); settle();
    chk("R9 expected change ignored", 32'(mismatch_alarm), 1);
    send_msg(ma, 16); send_msg(ma, 16); send_msg(mb, 16);
    send_msg(ma, 16); send_msg(ma, 16); settle();
    reg_read(2'b10, 0, v); chk("R8 restart", 32'(v), 32'(mb[0]));
    send_msg(ma, 16); settle();
    reg_read(2'b10, 0, v); chk("R8 restart accepted", 32'(v), 32'(ma[0]));
    send_msg(mb, 16); send_msg(mb, 16); send_msg(mb, 16); settle();
    chk("R9 mismatch cleared", 32'(mismatch_alarm), 0);

    // R6 64-byte receive
    do_reset(2'b10);
    mc = mk_long();
    load_msg(2'b01, mc, 64);
    send_msg(mc, 64); send_msg(mc, 64); send_msg(mc, 64); settle();
    reg_read(2'b10, 63, v); chk("R6 first pair aligns only", 32'(v), 0);
    send_msg(mc, 64); settle();
    reg_read(2'b10, 63, v); chk("R6 accepted end", 32'(v), 32'h0A);
    reg_read(2'b10, 10, v); chk("R6 accepted body", 32'(v), 32'(mc[10]));
    chk("R6 R9 match", 32'(mismatch_alarm), 0);

    // R7 single-byte receive
    do_reset(2'b00);
    reg_write(2'b01, 0, 8'h33);
    send_byte(8'h33); send_byte(8'h33); settle();
    reg_read(2'b10, 0, v); chk("R7 two not enough", 32'(v), 0);
    send_byte(8'h33); settle();
    reg_read(2'b10, 0, v); chk("R7 accepted", 32'(v), 32'h33);
    chk("R7 match", 32'(mismatch_alarm), 0);
    send_byte(8'h44); send_byte(8'h44); send_byte(8'h44); settle();
    chk("R7 mismatch", 32'(mismatch_alarm), 1);

    // R10 unstable, single byte: window 8
    do_reset(2'b00);
    for (int i = 1; i < 8; i++) send_byte(8'(i));
    settle(); chk("R10 single below window", 32'(trace_unstable), 0);
    send_byte(8'h08); settle();
    chk("R10 single window", 32'(trace_unstable), 1);

    // R10 unstable, 16-byte: window 128
    do_reset(2'b01);
    for (int i = 0; i < 127; i++) send_byte(8'($urandom) & 8'h7F);
    settle(); chk("R10 short below window", 32'(trace_unstable), 0);
    send_byte(8'h01); settle();
    chk("R10 short window", 32'(trace_unstable), 1);
    send_msg(ma, 16); send_msg(ma, 16); send_msg(ma, 16); settle();
    chk("R10 cleared by accept", 32'(trace_unstable), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule